// File: doc/BRIEF.md
# Camera Window Crop, Decimate and RGB565 Conversion

This block sits between a camera sensor port and a display path. It receives a byte-serial YUV 4:2:2 stream (one byte per accepted cycle, with frame-start and line-start flags), cuts a rectangular window out of each frame by trimming the left, right, top and bottom edges independently, and thins the window out horizontally and vertically with two independent fixed-point step ratios. Each surviving pixel is converted to RGB565 and handed out on a valid/ready stream that carries a first-pixel-of-frame flag and a last-pixel-of-line flag.

A byte state machine tracks the position inside each four-byte chroma group. Its states are `PH_WAIT_SOF` (idle until the first frame start), `PH_CB`, `PH_Y0`, `PH_CR` and `PH_Y1`. An accepted byte flagged as frame start leaves `PH_WAIT_SOF` for `PH_Y0`. An accepted byte flagged as line start, in any running state, is taken as a blue-difference byte and moves the machine to `PH_Y0`. Otherwise the machine walks `PH_CB`→`PH_Y0`→`PH_CR`→`PH_Y1`→`PH_CB`. An even pixel is produced while in `PH_CR` and an odd pixel while in `PH_Y1`.

Window and ratio settings are written through an 8-entry register port into a staging set. The staging set is copied to the working set when a frame-start byte is accepted, so a frame is always processed with one consistent setting.

Top module: `cam_yuv_scaler`

## Requirements
- R1: After reset `out_valid` is 0 and `in_rdy` is 1. The settings reset to a 640-pixel by 480-line source, zero trim on all sides and both steps at 1.0, so every pixel of every line is passed.
- R2: Bytes of a line arrive as Cb, Y0, Cr, Y1 repeated. Pixel 2k uses (Y0, Cb, Cr) and is emitted one cycle after the Cr byte is accepted. Pixel 2k+1 uses (Y1, Cb, Cr) and is emitted one cycle after the Y1 byte is accepted.
- R3: With d_b = Cb-128 and d_r = Cr-128, R = floor((256Y + 359d_r + 128)/256), G = floor((256Y - 88d_b - 183d_r + 128)/256) and B = floor((256Y + 454d_b + 128)/256). Each result is clamped to 0..255. The output word is {R[7:3], G[7:2], B[7:3]} in bits 15:11, 10:5 and 4:0.
- R4: Columns x < left trim and x ≥ source width − right trim are never emitted.
- R5: Lines y < top trim and y ≥ source height − bottom trim are never emitted. The line counter restarts at 0 on the frame-start byte.
- R6: Inside the window, the relative column i is kept if i = floor(k·h_step/256) for some integer k ≥ 0. The step is a 12-bit value with 8 fractional bits.
- R7: Relative lines follow the same rule with v_step. A step written below 256 is stored as 256.
- R8: Register addresses are 0 source width, 1 source height, 2 left, 3 right, 4 top, 5 bottom, 6 h_step and 7 v_step. Writes take effect from the next accepted frame-start byte, never in the middle of a frame.
- R9: `out_sof` is 1 only on the first emitted pixel of a frame. `out_eol` is 1 on the last emitted pixel of each kept line, that is, when the next kept relative column would fall at or beyond the window width.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_rdy` is 0 and the output word and flags hold. No pixel is lost or duplicated.
- R11: Bytes accepted before the first frame-start byte after reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input byte valid |
| in_rdy | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | YUV 4:2:2 byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_sol | input | 1 | Byte is the first of a line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the pixel |
| out_data | output | 16 | RGB565 pixel |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of line |

## Verification
The hardest case to reach is a register write that lands in the middle of a frame. The new window must stay invisible until the following frame start, and only the pixel count and positions show that. The bench writes a second setting through the port after the first line of a frame has been sent. It predicts that frame from the old setting and the next frame from the new one. Saturation in both directions is reached with an extreme byte pattern, and back-pressure is applied throughout by a pseudo-random ready signal combined with gaps in the input.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;
    localparam int COORD_W = 10;
    localparam int FRAC_W  = 8;
    localparam int STEP_W  = 12;
    localparam int ACC_W   = COORD_W + FRAC_W + 1;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 16;
    localparam int PIX_W   = 16;
    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1 << FRAC_W);

    typedef struct packed {
        logic [COORD_W-1:0] src_w;
        logic [COORD_W-1:0] src_h;
        logic [COORD_W-1:0] trim_l;
        logic [COORD_W-1:0] trim_r;
        logic [COORD_W-1:0] trim_t;
        logic [COORD_W-1:0] trim_b;
        logic [STEP_W-1:0]  h_step;
        logic [STEP_W-1:0]  v_step;
    } win_cfg_t;

    localparam win_cfg_t CFG_RESET = '{
        src_w: COORD_W'(640), src_h: COORD_W'(480),
        trim_l: '0, trim_r: '0, trim_t: '0, trim_b: '0,
        h_step: STEP_ONE, v_step: STEP_ONE
    };

    typedef enum logic [2:0] {PH_WAIT_SOF, PH_CB, PH_Y0, PH_CR, PH_Y1} phase_e;
endpackage

// File: rtl/cam_cfg_regs.sv
`timescale 1ns/1ps
module cam_cfg_regs
    import cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output win_cfg_t          cfg_eff
);
    win_cfg_t live_q, act_q;
    logic [COORD_W-1:0] wcoord;
    logic [STEP_W-1:0]  wstep;

    always_comb begin
        wcoord = wdata[COORD_W-1:0];
        wstep  = (wdata[STEP_W-1:0] < STEP_ONE) ? STEP_ONE : wdata[STEP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= CFG_RESET;
            act_q  <= CFG_RESET;
        end else begin
            if (load) act_q <= live_q;
            if (we) begin
                unique case (addr)
                    3'd0: live_q.src_w  <= wcoord;
                    3'd1: live_q.src_h  <= wcoord;
                    3'd2: live_q.trim_l <= wcoord;
                    3'd3: live_q.trim_r <= wcoord;
                    3'd4: live_q.trim_t <= wcoord;
                    3'd5: live_q.trim_b <= wcoord;
                    3'd6: live_q.h_step <= wstep;
                    3'd7: live_q.v_step <= wstep;
                endcase
            end
        end
    end

    assign cfg_eff = load ? live_q : act_q;
endmodule

// File: rtl/cam_scan_ctrl.sv
`timescale 1ns/1ps
module cam_scan_ctrl
    import cam_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line,
    input  logic     sof,
    input  logic     emit,
    input  logic     x_odd,
    input  win_cfg_t cfg,
    output logic     keep,
    output logic     last
);
    logic [COORD_W-1:0] y_q, ny, ry, x, rx;
    logic [COORD_W-2:0] pair_q;
    logic               ykeep_q, rowin, row_hit, colin;
    logic [ACC_W-1:0]   hnext_q, vnext_q, vbase, hadv;
    logic [COORD_W:0]   win_w;

    always_comb begin
        ny      = sof ? '0 : y_q + 1'b1;
        vbase   = sof ? '0 : vnext_q;
        rowin   = (ny >= cfg.trim_t) &&
                  (({1'b0, ny} + {1'b0, cfg.trim_b}) < {1'b0, cfg.src_h});
        ry      = ny - cfg.trim_t;
        row_hit = rowin && ({1'b0, ry} == vbase[ACC_W-1:FRAC_W]);
        x       = {pair_q, x_odd};
        colin   = (x >= cfg.trim_l) &&
                  (({1'b0, x} + {1'b0, cfg.trim_r}) < {1'b0, cfg.src_w});
        rx      = x - cfg.trim_l;
        hadv    = hnext_q + ACC_W'(cfg.h_step);
        win_w   = {1'b0, cfg.src_w} - {1'b0, cfg.trim_l} - {1'b0, cfg.trim_r};
        keep    = emit && ykeep_q && colin && ({1'b0, rx} == hnext_q[ACC_W-1:FRAC_W]);
        last    = hadv[ACC_W-1:FRAC_W] >= win_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q     <= '0;
            pair_q  <= '0;
            ykeep_q <= 1'b0;
            hnext_q <= '0;
            vnext_q <= '0;
        end else if (line) begin
            y_q     <= ny;
            ykeep_q <= row_hit;
            vnext_q <= row_hit ? vbase + ACC_W'(cfg.v_step) : vbase;
            hnext_q <= '0;
            pair_q  <= '0;
        end else begin
            if (emit && x_odd) pair_q  <= pair_q + 1'b1;
            if (keep)          hnext_q <= hadv;
        end
    end
endmodule

// File: rtl/cam_yuv2rgb.sv
`timescale 1ns/1ps
module cam_yuv2rgb
    import cam_pkg::*;
(
    input  logic [7:0]       luma,
    input  logic [7:0]       cb,
    input  logic [7:0]       cr,
    output logic [PIX_W-1:0] rgb
);
    function automatic logic [7:0] sat8(input logic signed [19:0] v);
        logic signed [19:0] s;
        s = v >>> 8;
        if (s < 0)        return 8'd0;
        else if (s > 255) return 8'd255;
        else              return s[7:0];
    endfunction

    logic signed [9:0]  db, dr;
    logic signed [19:0] yl, rs, gs, bs;
    logic [7:0] r8, g8, b8;

    always_comb begin
        db = $signed({2'b00, cb}) - 10'sd128;
        dr = $signed({2'b00, cr}) - 10'sd128;
        yl = $signed({4'b0000, luma, 8'h00});
        rs = yl + 20'sd359 * 20'(dr) + 20'sd128;
        gs = yl - 20'sd88 * 20'(db) - 20'sd183 * 20'(dr) + 20'sd128;
        bs = yl + 20'sd454 * 20'(db) + 20'sd128;
        r8 = sat8(rs);
        g8 = sat8(gs);
        b8 = sat8(bs);
        rgb = {r8[7:3], g8[7:2], b8[7:3]};
    end
endmodule

// File: rtl/cam_yuv_scaler.sv
`timescale 1ns/1ps
module cam_yuv_scaler
    import cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    output logic              in_rdy,
    input  logic [7:0]        in_byte,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_sof,
    output logic              out_eol
);
    phase_e st_q, st_d;
    logic acc, acc_eff, sol_eff, emit, x_odd, keep, last, sof_pend_q;
    logic [7:0] cb_q, y0_q, cr_q, cv_y, cv_cr;
    logic [PIX_W-1:0] rgb;
    win_cfg_t cfg;

    assign in_rdy  = !out_valid || out_ready;
    assign acc     = in_vld && in_rdy;
    assign sol_eff = in_sol || in_sof;
    assign acc_eff = acc && ((st_q != PH_WAIT_SOF) || in_sof);
    assign x_odd   = (st_q == PH_Y1);
    assign emit    = acc_eff && !sol_eff && ((st_q == PH_CR) || (st_q == PH_Y1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_WAIT_SOF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (acc) begin
            unique case (st_q)
                PH_WAIT_SOF: st_d = in_sof ? PH_Y0 : PH_WAIT_SOF;
                PH_CB:       st_d = PH_Y0;
                PH_Y0:       st_d = sol_eff ? PH_Y0 : PH_CR;
                PH_CR:       st_d = sol_eff ? PH_Y0 : PH_Y1;
                PH_Y1:       st_d = sol_eff ? PH_Y0 : PH_CB;
                default:     st_d = PH_WAIT_SOF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cb_q <= '0;
            y0_q <= '0;
            cr_q <= '0;
        end else if (acc_eff) begin
            if (sol_eff || st_q == PH_CB)   cb_q <= in_byte;
            if (!sol_eff && st_q == PH_Y0)  y0_q <= in_byte;
            if (!sol_eff && st_q == PH_CR)  cr_q <= in_byte;
        end
    end

    always_comb begin
        cv_y  = x_odd ? in_byte : y0_q;
        cv_cr = x_odd ? cr_q : in_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sof    <= 1'b0;
            out_eol    <= 1'b0;
            sof_pend_q <= 1'b0;
        end else begin
            if (keep) begin
                out_valid <= 1'b1;
                out_data  <= rgb;
                out_sof   <= sof_pend_q;
                out_eol   <= last;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (acc && in_sof) sof_pend_q <= 1'b1;
            else if (keep)     sof_pend_q <= 1'b0;
        end
    end

    cam_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .load(acc && in_sof), .cfg_eff(cfg)
    );

    cam_scan_ctrl u_scan (
        .clk(clk), .rst_n(rst_n), .line(acc_eff && sol_eff), .sof(acc && in_sof),
        .emit(emit), .x_odd(x_odd), .cfg(cfg), .keep(keep), .last(last)
    );

    cam_yuv2rgb u_conv (.luma(cv_y), .cb(cb_q), .cr(cv_cr), .rgb(rgb));
endmodule

// File: rtl/cam_yuv_scaler_chk.sv
`timescale 1ns/1ps
module cam_yuv_scaler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic        in_rdy,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_data,
    input logic        out_sof,
    input logic        out_eol
);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));
    // R2
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_vld && in_rdy));
    // R9
    sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_sof |=> !(out_valid && out_sof));
    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

bind cam_yuv_scaler cam_yuv_scaler_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/cam_yuv_scaler_tb_top.sv
`timescale 1ns/1ps
module cam_yuv_scaler_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 0, in_sof = 0, in_sol = 0, reg_we = 0, out_ready = 1;
    logic [7:0] in_byte = '0;
    logic [2:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic in_rdy, out_valid, out_sof, out_eol;
    logic [15:0] out_data;

    always #2.5 clk = ~clk;

    typedef struct { logic [15:0] d; logic s; logic e; string tag; } exp_t;
    typedef struct { int w, h, l, r, t, b, hs, vs; } mcfg_t;
    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    cam_yuv_scaler dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .in_byte(in_byte),
        .in_sof(in_sof), .in_sol(in_sol), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
    );

    function automatic int clip(int v);
        return (v < 0) ? 0 : (v > 255) ? 255 : v;
    endfunction

    // R3 reference conversion, written in split form
    function automatic logic [15:0] ref_rgb(int yy, int cb, int cr);
        int r, g, b;
        r = clip(yy + ((359 * (cr - 128) + 128) >>> 8));
        g = clip(yy + ((-88 * (cb - 128) - 183 * (cr - 128) + 128) >>> 8));
        b = clip(yy + ((454 * (cb - 128) + 128) >>> 8));
        return {5'(r >> 3), 6'(g >> 2), 5'(b >> 3)};
    endfunction

    function automatic int pat(int mode, int kind, int x, int y);
        if (mode == 1) begin
            if (kind == 0) return ((x >> 1) % 2 == 0) ? 0 : 255;
            if (kind == 1) return ((x >> 1) % 2 == 0) ? 255 : 0;
            return (x % 2 == 0) ? 255 : 0;
        end
        if (kind == 0) return ((x >> 1) * 29 + y * 3) & 255;
        if (kind == 1) return ((x >> 1) * 53 + y * 11 + 17) & 255;
        return (x * 7 + y * 13) & 255;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic write_reg(int a, int v);
        reg_we = 1; reg_addr = 3'(a); reg_wdata = 16'(v);
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic write_cfg(mcfg_t c);
        write_reg(0, c.w); write_reg(1, c.h); write_reg(2, c.l); write_reg(3, c.r);
        write_reg(4, c.t); write_reg(5, c.b); write_reg(6, c.hs); write_reg(7, c.vs);
    endtask

    task automatic send_byte(int b, bit s, bit l);
        in_vld = 1; in_byte = 8'(b); in_sof = s; in_sol = l;
        @(negedge clk);
        while (!in_rdy) @(negedge clk);
        @(posedge clk); #1;
        in_vld = 0; in_sof = 0; in_sol = 0;
        if ($urandom % 5 == 0) begin @(posedge clk); #1; end
    endtask

    // scoreboard driver: model the frame, push expected pixels, then stream bytes
    task automatic send_frame(mcfg_t m, int mode, int nlines, bit mid, mcfg_t nc, string tag);
        int hs, vs, kv, kh;
        bit first;
        exp_t e;
        exp_t line[$];
        hs = (m.hs < 256) ? 256 : m.hs;
        vs = (m.vs < 256) ? 256 : m.vs;
        kv = 0; first = 1;
        for (int y = 0; y < nlines; y++) begin
            if (y >= m.t && y < m.h - m.b && ((kv * vs) >> 8) == y - m.t) begin
                kv++; kh = 0; line.delete();
                for (int x = 0; x < m.w; x++) begin
                    if (x >= m.l && x < m.w - m.r && ((kh * hs) >> 8) == x - m.l) begin
                        kh++;
                        e.d = ref_rgb(pat(mode, 2, x, y), pat(mode, 0, x, y), pat(mode, 1, x, y));
                        e.s = first; e.e = 0; e.tag = tag; first = 0;
                        line.push_back(e);
                    end
                end
                if (line.size() > 0) line[line.size()-1].e = 1;
                foreach (line[i]) q.push_back(line[i]);
            end
        end
        for (int y = 0; y < nlines; y++) begin
            for (int p = 0; p < m.w / 2; p++) begin
                send_byte(pat(mode, 0, 2*p, y), (y == 0 && p == 0), (p == 0));
                send_byte(pat(mode, 2, 2*p, y), 0, 0);
                send_byte(pat(mode, 1, 2*p, y), 0, 0);
                send_byte(pat(mode, 2, 2*p+1, y), 0, 0);
            end
            if (mid && y == 0) write_cfg(nc); // R8 write lands mid-frame
        end
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(0, "R10 extra pixel", out_data, 0);
            end else begin
                e = q.pop_front();
                check(out_data == e.d, e.tag, out_data, e.d);
                check({out_sof, out_eol} == {e.s, e.e}, "R9 flags", {out_sof, out_eol}, {e.s, e.e});
            end
        end
    end

    // ready pattern for R10 back-pressure
    initial forever begin
        @(posedge clk); #1;
        out_ready = ($urandom % 3 != 0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R10 watchdog expired", q.size(), 0);
        finish_run();
    end

    initial begin
        mcfg_t dflt, c2, c3, c4, c5, ca, cb;
        dflt = '{640, 480, 0, 0, 0, 0, 256, 256};
        c2 = '{16, 8, 3, 2, 1, 2, 256, 256};
        c3 = '{20, 12, 1, 3, 2, 1, 384, 512};
        c4 = '{12, 6, 0, 0, 0, 0, 192, 100};
        c5 = '{8, 2, 0, 0, 0, 0, 256, 256};
        ca = '{16, 6, 2, 2, 0, 0, 256, 256};
        cb = '{16, 6, 0, 4, 1, 0, 512, 256};
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        check(in_rdy == 1, "R10 in_rdy after reset", in_rdy, 1);
        @(posedge clk); #1;
        // R11 bytes before any frame start
        for (int i = 0; i < 12; i++) send_byte(i * 37, 0, (i % 4 == 0));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 0, "R11 output before frame start", out_valid, 0);
        @(posedge clk); #1;
        // R1 R2 R3 defaults pass the whole line
        send_frame(dflt, 0, 2, 0, dflt, "R1/R2/R3 default");
        drain();
        write_cfg(c2);
        send_frame(c2, 0, 8, 0, c2, "R4/R5 crop");
        drain();
        write_cfg(c3);
        send_frame(c3, 0, 12, 0, c3, "R6/R7 scale");
        drain();
        write_cfg(c4);
        send_frame(c4, 0, 6, 0, c4, "R7 step clamp");
        drain();
        write_cfg(c5);
        send_frame(c5, 1, 2, 0, c5, "R3 saturation");
        drain();
        write_cfg(ca);
        send_frame(ca, 0, 6, 1, cb, "R8 old setting");
        drain();
        send_frame(cb, 0, 6, 0, cb, "R8 new setting");
        drain();
        check(q.size() == 0, "R10 missing pixels", q.size(), 0);
        finish_run();
    end
endmodule